// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch or a conditional operation is taken. It receives a condition selector and the four arithmetic status flags: carry, zero, sign and overflow. From them it forms one taken bit. The sixteen selector values form eight even/odd pairs, and the odd member of each pair is the exact inverse of the even member. The pairs cover the following tests:

- equality with zero
- carry-based unsigned ordering
- unsigned strictly-greater
- sign
- signed ordering
- signed strictly-greater
- overflow
- a constant pair (always true / never true)

The block reads only the low four bits of the selector. Any wider field passed in from an instruction word may therefore carry unrelated bits.

The evaluation itself is combinational. A parameter selects how the result is presented:

- Registered form (the default): a request strobe captures the selector and flags. The result and an output-valid strobe appear on the following clock. The result then holds until the next request.
- Pass-through form: the result follows the inputs directly, and the valid strobe mirrors the request.

A second parameter picks the decode structure: a pair-fold form or a flat sixteen-way form. Both implement the same function.

Top module: `branch_cond_unit`

## Requirements
- R1: Selector 0 yields taken equal to the zero flag; selector 1 yields its inverse.
- R2: Selector 2 yields taken equal to the carry flag (unsigned greater-or-equal); selector 3 yields its inverse (unsigned less-than).
- R3: Selector 4 is taken when carry is 1 and zero is 0 (unsigned greater-than); selector 5 is its inverse.
- R4: Selector 6 is taken when the sign flag is 0; selector 7 is taken when the sign flag is 1.
- R5: Selector 8 is taken when sign equals overflow (signed greater-or-equal); selector 9 is taken when they differ.
- R6: Selector 10 is taken when ((sign XOR overflow) OR zero) is 0 (signed greater-than); selector 11 is its inverse.
- R7: Selector 12 yields taken equal to the overflow flag; selector 13 yields its inverse.
- R8: Selector 14 is taken for every flag combination; selector 15 is never taken.
- R9: Only cond_code[3:0] is decoded; the bits above bit 3 have no effect on taken.
- R10: For every flag combination and every even selector e, the result for e+1 is the inverse of the result for e.
- R11: In the registered form, taken_valid is 1 in exactly the cycle after each cycle with req_valid at 1. The taken value in that cycle reflects the selector and flags present at the request edge. Back-to-back requests give back-to-back results.
- R12: While rst_n is 0 (asynchronous, active low), taken and taken_valid are 0.
- R13: In the registered form, taken keeps its last value in cycles that follow no request, whatever the flags and selector do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered form |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; captures selector and flags |
| cond_code | input | CODE_W | Condition selector; only bits [3:0] are decoded |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| taken | output | 1 | Condition result |
| taken_valid | output | 1 | Result strobe, one clock after req_valid |

## Verification
A vector table walks every selector with flag settings chosen to separate the even/odd pairs, with these aims:

- Unsigned greater-than is exercised with carry and zero both set, so that it cannot be confused with plain carry.
- Signed greater-than is exercised with equal sign and overflow plus zero set, so that it cannot be confused with signed greater-or-equal.
- Selectors with nonzero upper bits show that only the low nibble matters.

An exhaustive sweep over all sixteen flag combinations then confirms the complement pairing for every pair. Directed sequences separate three timing properties: one-cycle latency, back-to-back throughput, and holding of the result between requests. An asynchronous reset taken mid-stream shows that the outputs clear.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

   localparam int unsigned SEL_W     = 4;
   localparam int unsigned NUM_CODES = 1 << SEL_W;
   localparam int unsigned NUM_PAIRS = NUM_CODES / 2;
   localparam int unsigned PAIR_W    = SEL_W - 1;

   typedef struct packed {
      logic carry;
      logic zero;
      logic sign;
      logic ovf;
   } flags_t;

   // Index of each even-selector predicate; the odd selector inverts it.
   typedef enum logic [PAIR_W-1:0] {
      PR_EQ  = 3'd0,
      PR_GEU = 3'd1,
      PR_GTU = 3'd2,
      PR_PZ  = 3'd3,
      PR_GE  = 3'd4,
      PR_GT  = 3'd5,
      PR_OV  = 3'd6,
      PR_ALW = 3'd7
   } pair_e;

   localparam int unsigned DECODE_FOLD = 0;
   localparam int unsigned DECODE_FLAT = 1;

endpackage

// File: rtl/cond_predicates.sv
module cond_predicates
   import bcu_pkg::*;
(
   input  flags_t               flags,
   output logic [NUM_PAIRS-1:0] base
);

   logic sv_diff;

   always_comb begin
      sv_diff      = flags.sign ^ flags.ovf;
      base         = '0;
      base[PR_EQ]  = flags.zero;
      base[PR_GEU] = flags.carry;
      base[PR_GTU] = flags.carry & ~flags.zero;
      base[PR_PZ]  = ~flags.sign;
      base[PR_GE]  = ~sv_diff;
      base[PR_GT]  = ~(sv_diff | flags.zero);
      base[PR_OV]  = flags.ovf;
      base[PR_ALW] = 1'b1;
   end

endmodule

// File: rtl/cond_select.sv
module cond_select
   import bcu_pkg::*;
#(
   parameter int unsigned DECODE_STYLE = DECODE_FOLD
)(
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_PAIRS-1:0] base,
   output logic                 hit
);

   generate
      if (DECODE_STYLE == DECODE_FOLD) begin : g_fold
         logic [PAIR_W-1:0] pair_idx;
         assign pair_idx = sel[SEL_W-1:1];
         assign hit      = base[pair_idx] ^ sel[0];
      end else if (DECODE_STYLE == DECODE_FLAT) begin : g_flat
         logic [NUM_CODES-1:0] full;
         for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
            if ((i % 2) == 1) begin : g_odd
               assign full[i] = ~base[i/2];
            end else begin : g_even
               assign full[i] = base[i/2];
            end
         end
         assign hit = full[sel];
      end else begin : g_bad_style
         $error("cond_select: unsupported DECODE_STYLE %0d", DECODE_STYLE);
      end
   endgenerate

endmodule

// File: rtl/cond_result_stage.sv
module cond_result_stage #(
   parameter bit REGISTERED = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic hit,
   output logic taken,
   output logic valid
);

   generate
      if (REGISTERED) begin : g_reg
         logic taken_q;
         logic valid_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               taken_q <= 1'b0;
               valid_q <= 1'b0;
            end else begin
               valid_q <= req;
               if (req) begin
                  taken_q <= hit;
               end
            end
         end

         assign taken = taken_q;
         assign valid = valid_q;
      end else begin : g_comb
         assign taken = rst_n & hit;
         assign valid = rst_n & req;
      end
   endgenerate

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
   import bcu_pkg::*;
#(
   parameter int unsigned CODE_W       = 8,
   parameter bit          REGISTERED   = 1'b1,
   parameter int unsigned DECODE_STYLE = DECODE_FOLD
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CODE_W-1:0] cond_code,
   input  logic              flag_c,
   input  logic              flag_z,
   input  logic              flag_s,
   input  logic              flag_o,
   output logic              taken,
   output logic              taken_valid
);

   generate
      if (CODE_W < SEL_W) begin : g_bad_code_w
         $error("branch_cond_unit: CODE_W %0d narrower than selector", CODE_W);
      end
   endgenerate

   flags_t                flags;
   logic [SEL_W-1:0]      sel;
   logic [NUM_PAIRS-1:0]  base;
   logic                  hit;

   assign flags = '{carry: flag_c, zero: flag_z, sign: flag_s, ovf: flag_o};
   assign sel   = cond_code[SEL_W-1:0];

   cond_predicates u_pred (
      .flags (flags),
      .base  (base)
   );

   cond_select #(
      .DECODE_STYLE (DECODE_STYLE)
   ) u_sel (
      .sel  (sel),
      .base (base),
      .hit  (hit)
   );

   cond_result_stage #(
      .REGISTERED (REGISTERED)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_valid),
      .hit   (hit),
      .taken (taken),
      .valid (taken_valid)
   );

endmodule

// File: rtl/branch_cond_chk.sv
module branch_cond_chk #(
   parameter int unsigned CODE_W     = 8,
   parameter bit          REGISTERED = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [CODE_W-1:0] cond_code,
   input logic              flag_c,
   input logic              flag_z,
   input logic              flag_s,
   input logic              flag_o,
   input logic              taken,
   input logic              taken_valid
);

   generate
      if (REGISTERED) begin : g_reg_props
         // R11
         valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> taken_valid);
         // R11
         no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !taken_valid);
         // R13
         hold_between_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> $stable(taken));
         // R8
         always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd14) |=> taken);
         // R8
         never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd15) |=> !taken);
         // R1
         zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd0) |=> (taken == $past(flag_z)));
         // R2
         carry_geu_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd2) |=> (taken == $past(flag_c)));
         // R4
         sign_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd7) |=> (taken == $past(flag_s)));
         // R7
         ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd12) |=> (taken == $past(flag_o)));
         // R5
         signed_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cond_code[3:0] == 4'd8) |=> (taken == ($past(flag_s) == $past(flag_o))));
         if (CODE_W > 4) begin : g_upper
            // R9
            upper_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (req_valid && cond_code[CODE_W-1:4] != '0 && cond_code[3:0] == 4'd14) |=> taken);
         end
      end else begin : g_comb_props
         always_comb begin
            // R8
            if (rst_n && cond_code[3:0] == 4'd15) begin
               comb_never_chk: assert (!taken);
            end
         end
      end
   endgenerate

   // R12
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_clear_chk: assert (!taken && !taken_valid);
      end
   end

endmodule

bind branch_cond_unit branch_cond_chk #(
   .CODE_W     (CODE_W),
   .REGISTERED (REGISTERED)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .cond_code   (cond_code),
   .flag_c      (flag_c),
   .flag_z      (flag_z),
   .flag_s      (flag_s),
   .flag_o      (flag_o),
   .taken       (taken),
   .taken_valid (taken_valid)
);

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;

   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 8;
   localparam int NVEC       = 32;

   typedef struct packed {
      logic [7:0] code;
      logic [3:0] flg;   // {carry, zero, sign, ovf}
      logic       exp;
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{8'h00, 4'b0100, 1'b1, 4'd1},   // R1
      '{8'h00, 4'b0000, 1'b0, 4'd1},   // R1
      '{8'h01, 4'b0000, 1'b1, 4'd1},   // R1
      '{8'h01, 4'b0100, 1'b0, 4'd1},   // R1
      '{8'h02, 4'b1000, 1'b1, 4'd2},   // R2
      '{8'h03, 4'b1000, 1'b0, 4'd2},   // R2
      '{8'h03, 4'b0000, 1'b1, 4'd2},   // R2
      '{8'h04, 4'b1000, 1'b1, 4'd3},   // R3
      '{8'h04, 4'b1100, 1'b0, 4'd3},   // R3
      '{8'h04, 4'b0000, 1'b0, 4'd3},   // R3
      '{8'h05, 4'b1100, 1'b1, 4'd3},   // R3
      '{8'h05, 4'b1000, 1'b0, 4'd3},   // R3
      '{8'h06, 4'b0000, 1'b1, 4'd4},   // R4
      '{8'h07, 4'b0000, 1'b0, 4'd4},   // R4
      '{8'h07, 4'b0010, 1'b1, 4'd4},   // R4
      '{8'h08, 4'b0011, 1'b1, 4'd5},   // R5
      '{8'h08, 4'b0010, 1'b0, 4'd5},   // R5
      '{8'h09, 4'b0001, 1'b1, 4'd5},   // R5
      '{8'h0A, 4'b0000, 1'b1, 4'd6},   // R6
      '{8'h0A, 4'b0100, 1'b0, 4'd6},   // R6
      '{8'h0A, 4'b0010, 1'b0, 4'd6},   // R6
      '{8'h0A, 4'b0011, 1'b1, 4'd6},   // R6
      '{8'h0B, 4'b0010, 1'b1, 4'd6},   // R6
      '{8'h0B, 4'b0000, 1'b0, 4'd6},   // R6
      '{8'h0C, 4'b0001, 1'b1, 4'd7},   // R7
      '{8'h0D, 4'b0001, 1'b0, 4'd7},   // R7
      '{8'h0D, 4'b0000, 1'b1, 4'd7},   // R7
      '{8'h0E, 4'b0000, 1'b1, 4'd8},   // R8
      '{8'h0F, 4'b1111, 1'b0, 4'd8},   // R8
      '{8'hF0, 4'b0100, 1'b1, 4'd9},   // R9
      '{8'hA7, 4'b0010, 1'b1, 4'd9},   // R9
      '{8'h5E, 4'b0000, 1'b1, 4'd9}    // R9
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [CODE_W-1:0] cond_code = '0;
   logic              flag_c = 1'b0;
   logic              flag_z = 1'b0;
   logic              flag_s = 1'b0;
   logic              flag_o = 1'b0;
   logic              taken;
   logic              taken_valid;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   branch_cond_unit #(
      .CODE_W (CODE_W)
   ) i_branch_cond_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .cond_code   (cond_code),
      .flag_c      (flag_c),
      .flag_z      (flag_z),
      .flag_s      (flag_s),
      .flag_o      (flag_o),
      .taken       (taken),
      .taken_valid (taken_valid)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_flags(input logic [3:0] f);
      {flag_c, flag_z, flag_s, flag_o} = f;
   endtask

   // Drive a request at a falling edge; sample the result one clock later.
   task automatic issue(input logic [7:0] code, input logic [3:0] f,
                        output logic res, output logic vld);
      @(negedge clk);
      cond_code = code;
      set_flags(f);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      res = taken;
      vld = taken_valid;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic r0, r1, v0, v1;

      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12 taken in reset", taken, 1'b0);
      check("R12 valid in reset", taken_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 no valid without request", taken_valid, 1'b0);

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         issue(VECS[i].code, VECS[i].flg, r0, v0);
         check($sformatf("R%0d vec %0d valid", VECS[i].req, i), v0, 1'b1);
         check($sformatf("R%0d vec %0d code %h", VECS[i].req, i, VECS[i].code), r0, VECS[i].exp);
      end

      // R10: complement pairing, exhaustive over flags
      for (int e = 0; e < 16; e += 2) begin
         for (int f = 0; f < 16; f++) begin
            issue(8'(e), 4'(f), r0, v0);
            issue(8'(e + 1), 4'(f), r1, v1);
            check($sformatf("R10 pair %0d flags %0d", e, f), r1, ~r0);
         end
      end

      // R13: result holds between requests
      issue(8'h0E, 4'b0000, r0, v0);
      check("R13 setup taken", r0, 1'b1);
      cond_code = 8'h0F;
      set_flags(4'b1111);
      @(negedge clk);
      check("R13 valid low without request", taken_valid, 1'b0);
      set_flags(4'b0000);
      cond_code = 8'h01;
      @(negedge clk);
      check("R13 taken held", taken, 1'b1);

      // R11: back-to-back requests
      @(negedge clk);
      cond_code = 8'h0E;
      req_valid = 1'b1;
      @(negedge clk);
      cond_code = 8'h0F;
      check("R11 b2b first valid", taken_valid, 1'b1);
      check("R11 b2b first taken", taken, 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      check("R11 b2b second valid", taken_valid, 1'b1);
      check("R11 b2b second taken", taken, 1'b0);
      @(negedge clk);
      check("R11 valid drops", taken_valid, 1'b0);

      // R12: asynchronous reset mid-stream
      issue(8'h0E, 4'b0000, r0, v0);
      rst_n = 1'b0;
      #1;
      check("R12 async clear taken", taken, 1'b0);
      check("R12 async clear valid", taken_valid, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule